// File: doc/BRIEF.md
# Dual-Plane Protected Write Controller

This block sits between a simple synchronous bus and a byte-wide storage array that is split into two equal planes. The top address bit picks the plane. Each plane has its own write engine, so a program cycle in one plane never stalls reads from the other. A write first opens a short loading window in which further bytes of the same page can join. After that window the engine holds the plane busy for a fixed program time, and then it commits the gathered bytes into storage, one byte per clock. The storage is modelled as ordinary RAM, and the program time is an artificial delay.

Each write is screened in order before it reaches an engine. First comes a three-write unlock/lock command sequencer. Then comes a global software protection flag. Last comes a per-block write-enable mask, with the array cut into eight equal blocks. While a plane is busy, a read of it does not return array data. It returns a status byte in which one bit flips on every read, so software can poll until two reads agree. A write that reaches a busy plane and cannot join its open page is dropped, and a sticky error output records it.

The command sequencer has three states. SEQ_IDLE goes to SEQ_STEP1 when it sees key byte 0xAA at the first command address. SEQ_STEP1 goes to SEQ_STEP2 when it sees 0x55 at the second command address, and any other write sends it back to SEQ_IDLE. SEQ_STEP2 always returns to SEQ_IDLE. On the way it engages protection for 0xA0 at the first command address, or releases protection for 0x20 at that address. Each plane engine has four states. PL_IDLE goes to PL_LOAD on an accepted write. PL_LOAD stays in PL_LOAD while writes keep arriving, and goes to PL_PROG after LOAD_TO quiet clocks. PL_PROG goes to PL_COMMIT after PROG_CYC clocks. PL_COMMIT goes to PL_IDLE after walking all page slots.

Top module: `dpw_ctrl`

## Requirements
- R1: The address MSB selects the plane. A read of one plane returns its stored byte on `rdata` one clock after `rd_en`, even while the other plane is busy.
- R2: After the last accepted write, a plane stays busy for exactly LOAD_TO + PROG_CYC + 2^PAGE_W clocks. After that, reads of it return the written data.
- R3: A write to the same page (address bits above PAGE_W match) that arrives within LOAD_TO clocks of the previous accepted write joins the same cycle. A later write to the same offset overwrites the earlier one.
- R4: A read of a busy plane returns a byte that is zero except bit TOG_BIT. That bit is 1 on the first read in a cycle and inverts on each later read of that plane.
- R5: The three address MSBs select one of eight blocks. Bit i of the block mask set to 1 means block i is writable. `prot_we` loads the mask from `prot_mask`, and reset loads all ones. A write to a disabled block is ignored: data is unchanged and no error is raised.
- R6: While software protection is engaged, every ordinary write is ignored. Reset leaves protection released.
- R7: The sequence 0xAA at CMD_A1, then 0x55 at CMD_A2, then 0xA0 at CMD_A1 engages protection. The same sequence with 0x20 as the third byte releases it. Writes consumed by the sequence are never stored.
- R8: A write that does not match the expected step in the middle of the sequence aborts the sequence. That write is discarded, and the sequencer returns to its start state.
- R9: A screened write to a busy plane that cannot join its open page is dropped and sets `err_drop`. `err_drop` stays set until reset.
- R10: Out of reset, `rdata` and `err_drop` are zero.
- R11: `rdata` holds its value on clocks without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this clock |
| rd_en | input | 1 | Read request this clock |
| addr | input | ADDR_W | Byte address; MSB selects the plane |
| wdata | input | DATA_W | Write data |
| prot_we | input | 1 | Load the block-enable mask |
| prot_mask | input | 8 | New block-enable mask, 1 = writable |
| rdata | output | DATA_W | Registered read data or toggle status |
| err_drop | output | 1 | Sticky flag for a dropped write to a busy plane |

## Verification
The bench builds the block with a 9-bit address, 8-byte pages, a 4-clock loading window and a 6-clock program time. With these values a whole write cycle lasts 18 clocks. That keeps joins at the last legal clock, writes that land in PL_PROG, toggle polling through a complete cycle, and concurrent reads of the other plane all within a few hundred clocks. With these values the command addresses fall in different planes and blocks, so the sequencer is exercised across a protected block and across both engines.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_STEP1, SEQ_STEP2} seq_state_e;
    typedef enum logic [1:0] {PL_IDLE, PL_LOAD, PL_PROG, PL_COMMIT} pl_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] KEY_LOCK   = 8'hA0;
    localparam logic [7:0] KEY_UNLOCK = 8'h20;
endpackage

// File: rtl/dpw_seq.sv
module dpw_seq
    import dpw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CMD_A1 = 'h155,
    parameter logic [ADDR_W-1:0] CMD_A2 = 'h0AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              consume,
    output logic              sdp_on
);
    seq_state_e st_q, st_n;
    logic       sdp_n;
    logic       at_a1, at_a2;

    assign at_a1 = (addr == CMD_A1);
    assign at_a2 = (addr == CMD_A2);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            sdp_on <= 1'b0;
        end else begin
            st_q   <= st_n;
            sdp_on <= sdp_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n    = st_q;
        sdp_n   = sdp_on;
        consume = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                if (wr_en && at_a1 && wdata == DATA_W'(KEY_FIRST)) begin
                    consume = 1'b1;
                    st_n    = SEQ_STEP1;
                end
            end
            SEQ_STEP1: begin
                if (wr_en) begin
                    consume = 1'b1;
                    st_n = (at_a2 && wdata == DATA_W'(KEY_SECOND)) ? SEQ_STEP2 : SEQ_IDLE;
                end
            end
            SEQ_STEP2: begin
                if (wr_en) begin
                    consume = 1'b1;
                    st_n    = SEQ_IDLE;
                    if (at_a1 && wdata == DATA_W'(KEY_LOCK))
                        sdp_n = 1'b1;
                    else if (at_a1 && wdata == DATA_W'(KEY_UNLOCK))
                        sdp_n = 1'b0;
                end
            end
            default: st_n = SEQ_IDLE;
        endcase
    end
endmodule

// File: rtl/dpw_plane.sv
module dpw_plane
    import dpw_pkg::*;
#(
    parameter int PAW      = 11,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 4,
    parameter int LOAD_TO  = 16,
    parameter int PROG_CYC = 200,
    parameter int TOG_BIT  = 6,
    localparam int PAGE    = 1 << PAGE_W,
    localparam int DEPTH   = 1 << PAW,
    localparam int PGW     = PAW - PAGE_W,
    localparam int TMAX    = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC,
    localparam int TW      = $clog2(TMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [PAW-1:0]    wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic [PAW-1:0]    rd_addr,
    output logic              busy,
    output logic              loading,
    output logic [PGW-1:0]    cur_page,
    output logic [DATA_W-1:0] rdata
);
    pl_state_e         st_q, st_n;
    logic [TW-1:0]     tmr_q, tmr_n;
    logic [PAGE_W-1:0] idx_q, idx_n;
    logic [PAGE-1:0]   vld_q;
    logic              tog_q;
    logic [DATA_W-1:0] tog_word;
    logic [DATA_W-1:0] pbuf [PAGE];
    logic [DATA_W-1:0] mem  [DEPTH];
    logic              last_slot;

    assign busy      = (st_q != PL_IDLE);
    assign loading   = (st_q == PL_LOAD);
    assign last_slot = (idx_q == PAGE_W'(PAGE - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PL_IDLE;
            tmr_q <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_n;
            tmr_q <= tmr_n;
            idx_q <= idx_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_q;
        idx_n = idx_q;
        unique case (st_q)
            PL_IDLE: begin
                if (wr_go) begin
                    st_n  = PL_LOAD;
                    tmr_n = '0;
                end
            end
            PL_LOAD: begin
                if (wr_go) begin
                    tmr_n = '0;
                end else if (tmr_q == TW'(LOAD_TO - 1)) begin
                    st_n  = PL_PROG;
                    tmr_n = '0;
                end else begin
                    tmr_n = tmr_q + 1'b1;
                end
            end
            PL_PROG: begin
                if (tmr_q == TW'(PROG_CYC - 1)) begin
                    st_n  = PL_COMMIT;
                    idx_n = '0;
                end else begin
                    tmr_n = tmr_q + 1'b1;
                end
            end
            PL_COMMIT: begin
                if (last_slot) st_n = PL_IDLE;
                else           idx_n = idx_q + 1'b1;
            end
            default: st_n = PL_IDLE;
        endcase
    end

    always_comb begin
        tog_word          = '0;
        tog_word[TOG_BIT] = ~tog_q;
    end

    // outputs and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            tog_q    <= 1'b0;
            cur_page <= '0;
            rdata    <= '0;
        end else begin
            if (st_q == PL_COMMIT && last_slot) vld_q <= '0;
            if (wr_go) begin
                vld_q[wr_addr[PAGE_W-1:0]] <= 1'b1;
                cur_page <= wr_addr[PAW-1:PAGE_W];
            end
            if (wr_go && st_q == PL_IDLE)
                tog_q <= 1'b0;
            else if (rd_go && busy)
                tog_q <= ~tog_q;
            if (rd_go)
                rdata <= busy ? tog_word : mem[rd_addr];
        end
    end

    // storage, no reset
    always_ff @(posedge clk) begin
        if (wr_go) pbuf[wr_addr[PAGE_W-1:0]] <= wr_data;
        if (st_q == PL_COMMIT && vld_q[idx_q]) mem[{cur_page, idx_q}] <= pbuf[idx_q];
    end
endmodule

// File: rtl/dpw_ctrl.sv
module dpw_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 4,
    parameter int LOAD_TO  = 16,
    parameter int PROG_CYC = 200,
    parameter int TOG_BIT  = 6,
    parameter logic [ADDR_W-1:0] CMD_A1 = 'h155,
    parameter logic [ADDR_W-1:0] CMD_A2 = 'h0AA,
    parameter logic [7:0] MASK_INIT = 8'hFF,
    localparam int PAW   = ADDR_W - 1,
    localparam int PGW   = PAW - PAGE_W,
    localparam int BLK_W = 3,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prot_we,
    input  logic [NBLK-1:0]   prot_mask,
    output logic [DATA_W-1:0] rdata,
    output logic              err_drop
);
    logic              consume, sdp_on;
    logic [NBLK-1:0]   mask_q;
    logic [BLK_W-1:0]  blk;
    logic              plane_sel, allowed, drop, rd_sel_q;
    logic [1:0]        busy_v, loading_v, can_take, wr_go, rd_go;
    logic [PGW-1:0]    page_v [2];
    logic [DATA_W-1:0] prd    [2];

    assign plane_sel = addr[ADDR_W-1];
    assign blk       = addr[ADDR_W-1 -: BLK_W];
    assign allowed   = wr_en && !consume && !sdp_on && mask_q[blk];
    assign drop      = allowed && !can_take[plane_sel];

    dpw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_A1(CMD_A1), .CMD_A2(CMD_A2)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .consume(consume), .sdp_on(sdp_on)
    );

    for (genvar g = 0; g < 2; g++) begin : g_plane
        assign can_take[g] = !busy_v[g] ||
                             (loading_v[g] && page_v[g] == addr[PAW-1:PAGE_W]);
        assign wr_go[g]    = allowed && (plane_sel == 1'(g)) && can_take[g];
        assign rd_go[g]    = rd_en && (plane_sel == 1'(g));

        dpw_plane #(
            .PAW(PAW), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .LOAD_TO(LOAD_TO),
            .PROG_CYC(PROG_CYC), .TOG_BIT(TOG_BIT)
        ) u_plane (
            .clk(clk), .rst_n(rst_n),
            .wr_go(wr_go[g]), .wr_addr(addr[PAW-1:0]), .wr_data(wdata),
            .rd_go(rd_go[g]), .rd_addr(addr[PAW-1:0]),
            .busy(busy_v[g]), .loading(loading_v[g]), .cur_page(page_v[g]),
            .rdata(prd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= MASK_INIT;
            err_drop <= 1'b0;
            rd_sel_q <= 1'b0;
        end else begin
            if (prot_we) mask_q <= prot_mask;
            if (drop)    err_drop <= 1'b1;
            if (rd_en)   rd_sel_q <= plane_sel;
        end
    end

    assign rdata = rd_sel_q ? prd[1] : prd[0];
endmodule

module dpw_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              consume,
    input logic              sdp_on,
    input logic [7:0]        mask_q,
    input logic [1:0]        busy,
    input logic [1:0]        loading,
    input logic              err_drop
);
    logic       pl;
    logic [2:0] bk;
    assign pl = addr[ADDR_W-1];
    assign bk = addr[ADDR_W-1 -: 3];

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |=> err_drop);

    assert_busy_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !consume && !sdp_on && mask_q[bk] && busy[pl] && !loading[pl]) |=> err_drop);

    assert_locked_block_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !consume && !mask_q[bk] && !busy[pl]) |=> !busy[$past(pl)]);

    assert_sdp_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !consume && sdp_on && !busy[pl]) |=> !busy[$past(pl)]);

    assert_cmd_not_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && consume && !busy[pl]) |=> !busy[$past(pl)]);

    assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy[0]) |-> $past(wr_en && !addr[ADDR_W-1]));
endmodule

bind dpw_ctrl dpw_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .consume(consume),
    .sdp_on(sdp_on), .mask_q(mask_q), .busy(busy_v), .loading(loading_v),
    .err_drop(err_drop)
);

// File: tb/dpw_ctrl_bench.sv
module dpw_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 9;
    localparam int PW  = 3;
    localparam int LTO = 4;
    localparam int PCY = 6;
    localparam int PG  = 1 << PW;
    localparam int TOT = LTO + PCY + PG;
    localparam int A1  = 'h155;
    localparam int A2  = 'h0AA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, prot_we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, prot_mask = 8'hFF;
    logic [7:0] rdata;
    logic err_drop;

    dpw_ctrl #(
        .ADDR_W(AW), .DATA_W(8), .PAGE_W(PW), .LOAD_TO(LTO), .PROG_CYC(PCY),
        .TOG_BIT(6), .CMD_A1(9'h155), .CMD_A2(9'h0AA), .MASK_INIT(8'hFF)
    ) u_dpw_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .prot_we(prot_we), .prot_mask(prot_mask),
        .rdata(rdata), .err_drop(err_drop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    int remain [2];
    bit tog [2];
    int pg [2];
    bit acc [2];
    logic [7:0] mm [int];
    logic [7:0] mask_m;
    bit sdp_m, used;
    int seq_m, p, a, d;
    logic [7:0] exp_rd;
    bit exp_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            remain = '{0, 0}; tog = '{0, 0}; pg = '{0, 0};
            mask_m = 8'hFF; sdp_m = 0; seq_m = 0; exp_rd = 8'h00; exp_err = 0;
        end else begin
            acc = '{0, 0};
            a = int'(addr); d = int'(wdata);
            if (rd_en) begin
                p = a >> (AW-1);
                if (remain[p] > 0) begin
                    tog[p] = ~tog[p];
                    exp_rd = tog[p] ? 8'h40 : 8'h00;
                end else begin
                    exp_rd = mm.exists(a) ? mm[a] : 8'hxx;
                end
            end
            if (wr_en) begin
                used = 0;
                if (seq_m == 0) begin
                    if (a == A1 && d == 'hAA) begin seq_m = 1; used = 1; end
                end else if (seq_m == 1) begin
                    used = 1;
                    seq_m = (a == A2 && d == 'h55) ? 2 : 0;
                end else begin
                    used = 1;
                    if (a == A1 && d == 'hA0) sdp_m = 1;
                    else if (a == A1 && d == 'h20) sdp_m = 0;
                    seq_m = 0;
                end
                if (!used && !sdp_m && mask_m[a >> (AW-3)]) begin
                    p = a >> (AW-1);
                    if (remain[p] == 0 || (remain[p] > PCY + PG && pg[p] == (a >> PW))) begin
                        if (remain[p] == 0) tog[p] = 0;
                        remain[p] = TOT;
                        pg[p] = a >> PW;
                        mm[a] = wdata;
                        acc[p] = 1;
                    end else begin
                        exp_err = 1;
                    end
                end
            end
            for (int i = 0; i < 2; i++)
                if (!acc[i] && remain[i] > 0) remain[i]--;
            if (prot_we) mask_m = prot_mask;
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R10";

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, exp_rd, $time);
            end
            n_cmp++;
            if (err_drop !== exp_err) begin
                n_bad++;
                $display("FAIL %s err_drop actual=%b expected=%b t=%0t", cur_req, err_drop, exp_err, $time);
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic op(input bit w, input bit r, input int ad, input int dt);
        wr_en = w; rd_en = r; addr = AW'(ad); wdata = 8'(dt);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mask(input logic [7:0] m);
        prot_mask = m; prot_we = 1;
        @(negedge clk);
        prot_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R10"; idle(2);
        cur_req = "R2";  op(1,0,'h010,'h3C); idle(TOT+2); op(0,1,'h010,0); idle(1);
        cur_req = "R1";  op(1,0,'h110,'h5A); idle(TOT+2);
        op(1,0,'h020,'h11); op(0,1,'h110,0); op(0,1,'h110,0);
        cur_req = "R4";  op(0,1,'h020,0); op(0,1,'h020,0); op(0,1,'h021,0);
        idle(TOT); op(0,1,'h020,0);
        cur_req = "R3";  op(1,0,'h040,'hA1); idle(2); op(1,0,'h041,'hA2); idle(LTO-1);
        op(1,0,'h047,'hA7); op(1,0,'h041,'hB2); idle(TOT+2);
        op(0,1,'h040,0); op(0,1,'h041,0); op(0,1,'h047,0);
        cur_req = "R9";  op(1,0,'h048,'hC1); op(1,0,'h050,'hC2); idle(6);
        op(1,0,'h048,'hC3); idle(TOT+2); op(0,1,'h048,0); idle(2);
        cur_req = "R5";  op(1,0,'h090,'h11); idle(TOT+2); set_mask(8'hFB);
        op(1,0,'h090,'h77); idle(TOT+2); op(0,1,'h090,0);
        op(1,0,'h0D0,'h33); idle(TOT+2); op(0,1,'h0D0,0); set_mask(8'hFF);
        cur_req = "R7";  op(1,0,'h155,'h01); idle(TOT+2);
        op(1,0,A1,'hAA); op(1,0,A2,'h55); op(1,0,A1,'hA0);
        cur_req = "R6";  op(1,0,'h010,'h99); op(1,0,'h110,'h98); idle(TOT+2);
        op(0,1,'h010,0); op(0,1,'h110,0);
        cur_req = "R7";  op(1,0,A1,'hAA); op(1,0,A2,'h55); op(1,0,A1,'h20);
        op(0,1,'h155,0); op(1,0,'h010,'h66); idle(TOT+2); op(0,1,'h010,0);
        cur_req = "R8";  op(1,0,A1,'hAA); op(1,0,'h010,'h55); op(1,0,A1,'hA0);
        idle(TOT+2); op(0,1,A1,0); op(0,1,'h010,0);
        op(1,0,'h010,'h77); idle(TOT+2); op(0,1,'h010,0);
        cur_req = "R11"; idle(4);
        summary();
    end
endmodule